// File: doc/BRIEF.md
# 2B+D Channel Loopback Controller

This block sits between a time-division-multiplexed serial port that carries two bearer channels (B1, B2) and one signalling channel (D), and the transmit and receive paths toward the line. Three slot strobes say which channel the current bit belongs to. A small control register can turn the serial port back on itself for B1 only, for B2 only, or for all three channels. When a channel is turned back, the serial output carries the serial input bit instead of the bit received from the line.

A transparent bit decides what the line transmitter sees during looped slots. It either still gets the serial input bit, or it gets idle ones. A return-to-normal bit clears the loopback register and a CRC-corrupt control bit. The clear happens when that bit is written to one and then back to zero. Both outputs are registered, so each output bit follows its inputs by one clock. The loopback here does not depend on any loopback on the line side, and both can be active at the same time.

Top module: `tdm_loop_ctrl`

## Requirements
- R1: While reset is asserted and on release, `tdm_dout`, `line_tx_bit` and `crc_corrupt` are 0, and no channel is looped until the register is written.
- R2: With no loopback active for the current slot, `tdm_dout` equals the `line_rx_bit` of the previous cycle and `line_tx_bit` equals the `tdm_din` of the previous cycle.
- R3: Loop register (address 0) bit 3 loops B1 slots and bit 2 loops B2 slots. In a looped slot, `tdm_dout` equals the `tdm_din` of the previous cycle. Slots of the other channels are unaffected.
- R4: Loop register bit 1 loops B1, B2 and D slots, whatever the values of bits 3 and 2.
- R5: Loop register bit 0 is the transparent bit. In a looped slot, `line_tx_bit` is forced to 1 when the bit is 0, and follows `tdm_din` when the bit is 1. Slots that are not looped are never forced.
- R6: Writing 1 and then 0 to bit 0 of address 1 clears the loop register and the CRC-corrupt bit on the clock after the 0 is written. Writing the 1 alone clears nothing.
- R7: A register write made in the same cycle as the return-to-normal clear takes effect, and the clear does not override it.
- R8: Writing 0 to the loop register ends any loopback on the next clock.
- R9: Bit 0 of address 2 is the CRC-corrupt control bit, and it is driven on `crc_corrupt` from the clock after the write.
- R10: In a cycle where no slot strobe is high, no loopback or idle forcing applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 loop, 1 return-to-normal, 2 CRC-corrupt) |
| cfg_wdata | input | 8 | Register write data |
| b1_slot | input | 1 | Current bit belongs to B1 |
| b2_slot | input | 1 | Current bit belongs to B2 |
| d_slot | input | 1 | Current bit belongs to D |
| tdm_din | input | 1 | Serial port receive bit |
| line_rx_bit | input | 1 | Bit received from the line |
| tdm_dout | output | 1 | Serial port transmit bit |
| line_tx_bit | output | 1 | Bit sent toward the line transmitter |
| crc_corrupt | output | 1 | CRC-corrupt control bit |

## Verification
The return-to-normal clear and an ordinary register write can land on the same clock edge. The bench provokes this by writing 1 and then 0 to the return-to-normal bit, and then writing a new loop value on the very next cycle. It then reads the result back through the data path: B1 must be looped and B2 must not, which shows that the write won. All sixteen loop-register values are also swept against every slot type and every pair of input bits, with expected outputs worked out arithmetically.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
  localparam int NUM_CH   = 3;
  localparam int CH_D     = 0;
  localparam int CH_B2    = 1;
  localparam int CH_B1    = 2;
  localparam int LOOP_ADR = 0;
  localparam int RTN_ADR  = 1;
  localparam int CRC_ADR  = 2;

  // bit order matches register bits 3..0
  typedef struct packed {
    logic lp_b1;
    logic lp_b2;
    logic lp_all;
    logic transp;
  } loop_cfg_t;
endpackage

// File: rtl/tlc_regs.sv
module tlc_regs
  import tlc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output loop_cfg_t         cfg,
  output logic              crc_bit,
  output logic              rtn_fall
);
  localparam logic [ADDR_W-1:0] A_LOOP = ADDR_W'(LOOP_ADR);
  localparam logic [ADDR_W-1:0] A_RTN  = ADDR_W'(RTN_ADR);
  localparam logic [ADDR_W-1:0] A_CRC  = ADDR_W'(CRC_ADR);

  loop_cfg_t cfg_q, cfg_d;
  logic      crc_q, crc_d;
  logic      rtn_q, rtn_d;
  logic      rtn_dly_q;
  logic      upd_en;

  assign rtn_fall = rtn_dly_q & ~rtn_q;
  assign upd_en   = we | rtn_fall;

  always_comb begin
    cfg_d = cfg_q;
    crc_d = crc_q;
    rtn_d = rtn_q;
    if (rtn_fall) begin
      cfg_d = '0;
      crc_d = 1'b0;
    end
    if (we) begin
      unique case (addr)
        A_LOOP:  cfg_d = loop_cfg_t'(wdata[3:0]);
        A_RTN:   rtn_d = wdata[0];
        A_CRC:   crc_d = wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      crc_q <= 1'b0;
      rtn_q <= 1'b0;
    end else if (upd_en) begin
      cfg_q <= cfg_d;
      crc_q <= crc_d;
      rtn_q <= rtn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rtn_dly_q <= 1'b0;
    else        rtn_dly_q <= rtn_q;
  end

  assign cfg     = cfg_q;
  assign crc_bit = crc_q;
endmodule

// File: rtl/tlc_sel.sv
module tlc_sel
  import tlc_pkg::*;
(
  input  loop_cfg_t         cfg,
  input  logic [NUM_CH-1:0] slot,
  output logic              loop_en,
  output logic              idle_en
);
  logic [NUM_CH-1:0] ch_sel;
  logic [NUM_CH-1:0] ch_loop;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i == CH_B1) begin : g_b1
      assign ch_sel[i] = cfg.lp_b1;
    end else if (i == CH_B2) begin : g_b2
      assign ch_sel[i] = cfg.lp_b2;
    end else begin : g_d
      assign ch_sel[i] = 1'b0;
    end
    assign ch_loop[i] = slot[i] & (cfg.lp_all | ch_sel[i]);
  end

  assign loop_en = |ch_loop;
  assign idle_en = loop_en & ~cfg.transp;
endmodule

// File: rtl/tlc_path.sv
module tlc_path (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic idle_en,
  input  logic tdm_din,
  input  logic line_rx_bit,
  output logic tdm_dout,
  output logic line_tx_bit
);
  logic dout_d, dout_q;
  logic ltx_d, ltx_q;

  always_comb begin
    dout_d = loop_en ? tdm_din : line_rx_bit;
    ltx_d  = idle_en ? 1'b1 : tdm_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 1'b0;
      ltx_q  <= 1'b0;
    end else begin
      dout_q <= dout_d;
      ltx_q  <= ltx_d;
    end
  end

  assign tdm_dout    = dout_q;
  assign line_tx_bit = ltx_q;
endmodule

// File: rtl/tdm_loop_ctrl.sv
module tdm_loop_ctrl
  import tlc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              b1_slot,
  input  logic              b2_slot,
  input  logic              d_slot,
  input  logic              tdm_din,
  input  logic              line_rx_bit,
  output logic              tdm_dout,
  output logic              line_tx_bit,
  output logic              crc_corrupt
);
  loop_cfg_t         loop_cfg;
  logic              rtn_fall;
  logic              loop_en;
  logic              idle_en;
  logic [NUM_CH-1:0] slot_vec;

  always_comb begin
    slot_vec        = '0;
    slot_vec[CH_B1] = b1_slot;
    slot_vec[CH_B2] = b2_slot;
    slot_vec[CH_D]  = d_slot;
  end

  tlc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cfg(loop_cfg), .crc_bit(crc_corrupt), .rtn_fall(rtn_fall)
  );

  tlc_sel u_sel (
    .cfg(loop_cfg), .slot(slot_vec), .loop_en(loop_en), .idle_en(idle_en)
  );

  tlc_path u_path (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .idle_en(idle_en),
    .tdm_din(tdm_din), .line_rx_bit(line_rx_bit),
    .tdm_dout(tdm_dout), .line_tx_bit(line_tx_bit)
  );
endmodule

// File: rtl/tlc_chk.sv
module tlc_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              b1_slot,
  input logic              b2_slot,
  input logic              d_slot,
  input logic              tdm_din,
  input logic              line_rx_bit,
  input logic              tdm_dout,
  input logic              line_tx_bit,
  input logic              crc_corrupt,
  input logic [3:0]        loop_cfg,
  input logic              rtn_fall
);
  logic any_slot;
  assign any_slot = b1_slot | b2_slot | d_slot;

  assert_rtn_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rtn_fall && !cfg_we) |=> (loop_cfg == 4'd0 && !crc_corrupt));

  assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rtn_fall && cfg_we && cfg_addr == '0) |=> (loop_cfg == $past(cfg_wdata[3:0])));

  assert_idle_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_cfg[1] && !loop_cfg[0] && any_slot) |=> line_tx_bit);

  assert_all_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_cfg[1] && any_slot) |=> (tdm_dout == $past(tdm_din)));

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_cfg == 4'd0) |=> (tdm_dout == $past(line_rx_bit) && line_tx_bit == $past(tdm_din)));

  assert_no_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_slot) |=> (tdm_dout == $past(line_rx_bit) && line_tx_bit == $past(tdm_din)));
endmodule

bind tdm_loop_ctrl tlc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .b1_slot(b1_slot), .b2_slot(b2_slot), .d_slot(d_slot),
  .tdm_din(tdm_din), .line_rx_bit(line_rx_bit), .tdm_dout(tdm_dout),
  .line_tx_bit(line_tx_bit), .crc_corrupt(crc_corrupt),
  .loop_cfg(loop_cfg), .rtn_fall(rtn_fall)
);

// File: tb/tdm_loop_ctrl_tb.sv
module tdm_loop_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       b1_slot = 1'b0, b2_slot = 1'b0, d_slot = 1'b0;
  logic       tdm_din = 1'b0, line_rx_bit = 1'b0;
  logic       tdm_dout, line_tx_bit, crc_corrupt;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  tdm_loop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .b1_slot(b1_slot), .b2_slot(b2_slot), .d_slot(d_slot),
    .tdm_din(tdm_din), .line_rx_bit(line_rx_bit),
    .tdm_dout(tdm_dout), .line_tx_bit(line_tx_bit), .crc_corrupt(crc_corrupt)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // slot: 0 none, 1 B1, 2 B2, 3 D
  task automatic drive(input int slot, input logic s, input logic l);
    b1_slot = (slot == 1); b2_slot = (slot == 2); d_slot = (slot == 3);
    tdm_din = s; line_rx_bit = l;
    @(negedge clk);
    b1_slot = 1'b0; b2_slot = 1'b0; d_slot = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 dout in reset", tdm_dout, 1'b0);
    check("R1 line_tx in reset", line_tx_bit, 1'b0);
    check("R1 crc in reset", crc_corrupt, 1'b0);
    #3 rst_n = 1'b1;
    @(negedge clk);
    check("R1 crc after release", crc_corrupt, 1'b0);
    drive(1, 1'b0, 1'b1);
    check("R1 no loop after reset", tdm_dout, 1'b1);

    // sweep all loop register values, slot types and input pairs
    for (int cfg = 0; cfg < 16; cfg++) begin
      wr(2'd0, 8'(cfg));
      for (int slot = 0; slot < 4; slot++) begin
        for (int v = 0; v < 4; v++) begin
          logic s, l, lp, exp_o, exp_t;
          string tg;
          s = v[1]; l = v[0];
          lp = (slot == 1 && (cfg[3] || cfg[1])) ||
               (slot == 2 && (cfg[2] || cfg[1])) ||
               (slot == 3 && cfg[1]);
          exp_o = lp ? s : l;
          exp_t = (lp && !cfg[0]) ? 1'b1 : s;
          if (slot == 0)   tg = "R10 sweep";
          else if (cfg[1]) tg = "R4 sweep";
          else if (lp)     tg = "R3 sweep";
          else             tg = "R2 sweep";
          drive(slot, s, l);
          check($sformatf("%s dout cfg=%0d slot=%0d v=%0d", tg, cfg, slot, v), tdm_dout, exp_o);
          check($sformatf("R5 line_tx cfg=%0d slot=%0d v=%0d", cfg, slot, v), line_tx_bit, exp_t);
        end
      end
    end

    // R9 crc-corrupt bit
    wr(2'd2, 8'h01);
    check("R9 crc set", crc_corrupt, 1'b1);
    wr(2'd2, 8'h00);
    check("R9 crc cleared by write", crc_corrupt, 1'b0);

    // R8 direct clear
    wr(2'd0, 8'h08);
    drive(1, 1'b1, 1'b0);
    check("R8 b1 looped before clear", tdm_dout, 1'b1);
    wr(2'd0, 8'h00);
    drive(1, 1'b1, 1'b0);
    check("R8 b1 not looped after zero write", tdm_dout, 1'b0);

    // R6 return to normal
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h01);
    wr(2'd1, 8'h01);
    check("R6 set alone keeps crc", crc_corrupt, 1'b1);
    drive(3, 1'b1, 1'b0);
    check("R6 set alone keeps loop", tdm_dout, 1'b1);
    wr(2'd1, 8'h00);
    drive(0, 1'b0, 1'b0);
    check("R6 crc cleared", crc_corrupt, 1'b0);
    drive(3, 1'b1, 1'b0);
    check("R6 loop cleared dout", tdm_dout, 1'b0);
    check("R6 loop cleared line_tx", line_tx_bit, 1'b1);
    drive(3, 1'b0, 1'b1);
    check("R6 loop cleared line_tx follows", line_tx_bit, 1'b0);

    // R7 write lands with the clear
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h08);
    drive(1, 1'b1, 1'b0);
    check("R7 b1 looped by same-cycle write", tdm_dout, 1'b1);
    drive(2, 1'b1, 1'b0);
    check("R7 b2 not looped", tdm_dout, 1'b0);
    drive(3, 1'b1, 1'b0);
    check("R7 d not looped", tdm_dout, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule